// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned N-bit integers over several clock cycles. It uses a single N-bit adder instead of an array of adders. It holds three pieces of state:

- an N-bit copy of the multiplicand;
- one 2N-bit product register, whose lower half starts out holding the multiplier operand;
- a small step counter.

On every working cycle the block looks at the least significant bit of the product register. When that bit is set, the multiplicand is added into the upper half. In the same register update, the whole register, together with the adder's carry, moves one place to the right.

A client pulses a start strobe with both operands while the block is idle. The block then stays busy for exactly N cycles and raises a one-cycle completion pulse. The upper and lower words of the 2N-bit result are then available on two separate outputs. They stay there until the next accepted start.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is asserted (rst_n low), busy_o and done_o are 0 and hi_o and lo_o are all zeros.
- R2: A start_i pulse seen at a clock edge while busy_o is 0 is accepted. After that edge busy_o is 1, hi_o is zero and lo_o equals the multiplier operand.
- R3: On each busy cycle, when lo_o bit 0 is 1, the multiplicand is added to hi_o. The (N+1)-bit sum and lo_o are then shifted right one place as one 2N-bit value. After k steps, {hi_o, lo_o} equals (A * (B mod 2^k)) * 2^(N-k) + (B >> k).
- R4: The adder's carry-out enters the most significant bit of hi_o during the shift, so no sum bit is lost. With both operands all ones, the result is {all ones except bit 0 clear, 0...01}.
- R5: busy_o stays 1 for exactly N cycles after an accepted start. done_o is then 1 for exactly one cycle, at the same time as busy_o returns to 0.
- R6: When done_o is 1, {hi_o, lo_o} equals A * B, with hi_o the upper N bits and lo_o the lower N bits. Both hold that value until the next accepted start.
- R7: A start_i pulse while busy_o is 1 is ignored: neither the operands in use nor the cycle count change.
- R8: With N = 4, A = 2 and B = 3, {hi_o, lo_o} after the start edge and each of the four steps reads 0x03, 0x11, 0x18, 0x0C, 0x06.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication; taken only while idle |
| mcand_i | input | WIDTH | Multiplicand operand A |
| mplier_i | input | WIDTH | Multiplier operand B |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | One-cycle pulse when the product is complete |
| hi_o | output | WIDTH | Upper half of the product register |
| lo_o | output | WIDTH | Lower half of the product register |

## Verification
The bench builds two copies of the block. The first uses WIDTH = 4, which makes every one of the 256 operand pairs reachable and lets the short register trace be checked state by state. The second uses the default WIDTH = 32, which brings in a 5-bit step counter, the all-ones carry case, single high-bit operands, and back-to-back starts issued on the completion cycle. Both copies are compared on every clock against a closed-form expression for the register value after k steps, not against a step-by-step copy of the datapath.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl
  import shiftadd_mul_pkg::*;
#(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

  mul_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic           done_q;
  logic           last_step;

  assign load_o    = start_i && (state_q == ST_IDLE);
  assign step_o    = (state_q == ST_RUN);
  assign last_step = step_o && (cnt_q == LAST_CNT);
  assign busy_o    = step_o;
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          if (last_step) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> busy_o && !done_o);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> cnt_q <= LAST_CNT);
  // R5
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done_o && !busy_o);
  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !last_step) |=> busy_o && (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/shiftadd_mul_dp.sv
module shiftadd_mul_dp #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  output logic [N-1:0] hi_o,
  output logic [N-1:0] lo_o
);
  localparam int PW = 2 * N;

  // Conditional add on the upper half, carry kept in the extra bit.
  function automatic logic [N:0] cond_add(input logic [N-1:0] upper,
                                          input logic [N-1:0] m,
                                          input logic         en);
    return en ? ({1'b0, upper} + {1'b0, m}) : {1'b0, upper};
  endfunction

  // Right shift of carry, sum and lower half as one value.
  function automatic logic [PW-1:0] shift_join(input logic [N:0]   upper_ext,
                                               input logic [N-1:0] lower);
    return {upper_ext, lower[N-1:1]};
  endfunction

  logic [N-1:0]  mcand_q;
  logic [PW-1:0] prod_q;
  logic          add_fire;
  logic [N:0]    sum_ext;
  logic          carry_out;
  logic [PW-1:0] prod_next;

  assign add_fire  = step_i && prod_q[0];
  assign sum_ext   = cond_add(prod_q[PW-1:N], mcand_q, prod_q[0]);
  assign carry_out = add_fire && sum_ext[N];
  assign prod_next = shift_join(sum_ext, prod_q[N-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{N{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q  <= prod_next;
    end
  end

  assign hi_o = prod_q[PW-1:N];
  assign lo_o = prod_q[N-1:0];

  // R2
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (hi_o == '0) && (lo_o == $past(mplier_i)));
  // R3
  lower_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> lo_o[N-2:0] == $past(lo_o[N-1:1]));
  // R3
  no_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !prod_q[0]) |=> hi_o == ($past(hi_o) >> 1));
  // R4
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |=> hi_o[N-1]);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(prod_q));
  // R7
  mcand_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> $stable(mcand_q));
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  logic load_w;
  logic step_w;

  shiftadd_mul_ctrl #(.N(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load_w),
    .step_o  (step_w),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  shiftadd_mul_dp #(.N(WIDTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_w),
    .step_i   (step_w),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !busy_o && !done_o);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !load_w) |=> $stable(hi_o) && $stable(lo_o));
endmodule

// File: tb/shiftadd_mul_tb.sv
module shiftadd_mul_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit started = 0;
  bit finished = 0;

  logic s4_start = 0;
  logic [3:0] s4_a = 0, s4_b = 0;
  logic b4_busy, b4_done;
  logic [3:0] b4_hi, b4_lo;

  logic s32_start = 0;
  logic [31:0] s32_a = 0, s32_b = 0;
  logic b32_busy, b32_done;
  logic [31:0] b32_hi, b32_lo;

  shiftadd_mul #(.WIDTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(s4_start), .mcand_i(s4_a), .mplier_i(s4_b),
    .busy_o(b4_busy), .done_o(b4_done), .hi_o(b4_hi), .lo_o(b4_lo));

  shiftadd_mul #(.WIDTH(32)) u_dut_w32 (
    .clk(clk), .rst_n(rst_n), .start_i(s32_start), .mcand_i(s32_a), .mplier_i(s32_b),
    .busy_o(b32_busy), .done_o(b32_done), .hi_o(b32_hi), .lo_o(b32_lo));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Closed form of the register after k steps.
  function automatic logic [127:0] reg_after(input logic [63:0] a, input logic [63:0] b,
                                             input int k, input int n);
    logic [63:0] bm;
    logic [127:0] pp;
    bm = (k >= 64) ? b : (b & ((64'd1 << k) - 64'd1));
    pp = 128'(a) * 128'(bm);
    return (pp << (n - k)) | 128'(b >> k);
  endfunction

  // Reference state, one set per instance.
  bit m4_busy, m4_done, m4_valid;
  int m4_k;
  logic [63:0] m4_a, m4_b;
  bit m32_busy, m32_done, m32_valid;
  int m32_k;
  logic [63:0] m32_a, m32_b;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m4_busy = 0; m4_done = 0; m4_valid = 0; m4_k = 0;
      m32_busy = 0; m32_done = 0; m32_valid = 0; m32_k = 0;
    end else begin
      m4_done = 0;
      if (m4_busy) begin
        m4_k++;
        if (m4_k == 4) begin m4_busy = 0; m4_done = 1; end
      end else if (s4_start) begin
        m4_a = 64'(s4_a); m4_b = 64'(s4_b); m4_k = 0; m4_busy = 1; m4_valid = 1;
      end
      m32_done = 0;
      if (m32_busy) begin
        m32_k++;
        if (m32_k == 32) begin m32_busy = 0; m32_done = 1; end
      end else if (s32_start) begin
        m32_a = 64'(s32_a); m32_b = 64'(s32_b); m32_k = 0; m32_busy = 1; m32_valid = 1;
      end
    end
  end

  function automatic string tag_of(input bit rst, input bit busy, input bit done,
                                   input int k);
    if (rst) return "R1";
    if (done) return "R6";
    if (busy && k == 0) return "R2";
    if (busy) return "R3";
    return "R6";
  endfunction

  always @(negedge clk) begin
    if (started) begin
      logic [127:0] e4, e32;
      string t4, t32;
      e4  = m4_valid  ? reg_after(m4_a, m4_b, m4_k, 4)     : '0;
      e32 = m32_valid ? reg_after(m32_a, m32_b, m32_k, 32) : '0;
      t4  = tag_of(!rst_n, m4_busy, m4_done, m4_k);
      t32 = tag_of(!rst_n, m32_busy, m32_done, m32_k);
      chk(b4_busy == m4_busy, rst_n ? "R5 busy w4" : "R1 busy w4", b4_busy, m4_busy);
      chk(b4_done == m4_done, rst_n ? "R5 done w4" : "R1 done w4", b4_done, m4_done);
      chk({b4_hi, b4_lo} == e4[7:0], {t4, " product w4"}, {b4_hi, b4_lo}, e4);
      chk(b32_busy == m32_busy, rst_n ? "R5 busy w32" : "R1 busy w32", b32_busy, m32_busy);
      chk(b32_done == m32_done, rst_n ? "R5 done w32" : "R1 done w32", b32_done, m32_done);
      chk({b32_hi, b32_lo} == e32[63:0], {t32, " product w32"}, {b32_hi, b32_lo}, e32);
    end
  end

  task automatic run4(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    s4_a = a; s4_b = b; s4_start = 1;
    @(negedge clk);
    s4_start = 0;
    while (!b4_done) @(negedge clk);
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    s32_a = a; s32_b = b; s32_start = 1;
    @(negedge clk);
    s32_start = 0;
    while (!b32_done) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R8: register trace for 2 x 3 with four-bit operands
    @(negedge clk);
    s4_a = 4'd2; s4_b = 4'd3; s4_start = 1;
    @(negedge clk);
    s4_start = 0;
    chk({b4_hi, b4_lo} == 8'h03, "R8 trace load", {b4_hi, b4_lo}, 8'h03);
    @(negedge clk);
    chk({b4_hi, b4_lo} == 8'h11, "R8 trace step1", {b4_hi, b4_lo}, 8'h11);
    @(negedge clk);
    chk({b4_hi, b4_lo} == 8'h18, "R8 trace step2", {b4_hi, b4_lo}, 8'h18);
    @(negedge clk);
    chk({b4_hi, b4_lo} == 8'h0C, "R8 trace step3", {b4_hi, b4_lo}, 8'h0C);
    @(negedge clk);
    chk({b4_hi, b4_lo} == 8'h06 && b4_done, "R8 trace step4", {b4_hi, b4_lo}, 8'h06);

    // R7: a second start while busy must not disturb the running product
    @(negedge clk);
    s4_a = 4'd5; s4_b = 4'd7; s4_start = 1;
    @(negedge clk);
    s4_a = 4'd15; s4_b = 4'd15;
    @(negedge clk);
    s4_start = 0;
    while (!b4_done) @(negedge clk);
    chk({b4_hi, b4_lo} == 8'd35, "R7 start ignored while busy", {b4_hi, b4_lo}, 8'd35);
    repeat (3) @(negedge clk);
    chk({b4_hi, b4_lo} == 8'd35, "R6 result held", {b4_hi, b4_lo}, 8'd35);

    // Every four-bit operand pair
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        run4(4'(a), 4'(b));
        chk({b4_hi, b4_lo} == 8'(a * b), "R6 exhaustive w4", {b4_hi, b4_lo}, a * b);
      end

    // R4: carry out of the adder at full width
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk({b32_hi, b32_lo} == 64'hFFFF_FFFE_0000_0001, "R4 all ones carry",
        {b32_hi, b32_lo}, 64'hFFFF_FFFE_0000_0001);
    // back-to-back: start issued on the done cycle
    s32_a = 32'h8000_0000; s32_b = 32'd2; s32_start = 1;
    @(negedge clk);
    s32_start = 0;
    chk(b32_busy, "R2 start on done cycle", b32_busy, 1);
    while (!b32_done) @(negedge clk);
    chk({b32_hi, b32_lo} == 64'h1_0000_0000, "R6 high bit times two",
        {b32_hi, b32_lo}, 64'h1_0000_0000);
    run32(32'd0, 32'hDEAD_BEEF);
    run32(32'd1, 32'hFFFF_FFFF);
    run32(32'h1234_5678, 32'h9ABC_DEF0);
    run32(32'hFFFF_FFFF, 32'h8000_0001);
    chk({b32_hi, b32_lo} == 64'(64'hFFFF_FFFF * 64'h8000_0001), "R4 carry mixed",
        {b32_hi, b32_lo}, 64'hFFFF_FFFF * 64'h8000_0001);
    repeat (2) @(negedge clk);

    // R1: assert reset in the middle of a run
    @(negedge clk);
    s32_a = 32'd77; s32_b = 32'd99; s32_start = 1;
    @(negedge clk);
    s32_start = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(!b32_busy && {b32_hi, b32_lo} == 64'd0, "R1 reset mid run", {b32_hi, b32_lo}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    finished = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R5 actual=hung expected=complete");
      summary();
    end
  end
endmodule